// File: doc/BRIEF.md
# Byte-Coded Stack Machine Execute Stage

This block is the execute stage of a 16-bit stack processor whose program is a stream of byte opcodes. Each cycle in which `op_valid` is high, the front end presents one opcode together with up to two literal bytes already gathered from the stream. The stage updates a three-deep register window that holds the top three data-stack elements. It also updates a one-word return-stack top, a two-bit status register (carry in bit 0, zero in bit 1) and a file of 32 user variables. For branch opcodes it reports whether the branch is taken, so the front end can redirect its fetch.

The deeper stack storage lies outside the block. When the window overflows, the stage spills its third element through `ds_push`/`ds_spill`. When it underflows, it asks for one or two words through `ds_pop` and reads them the same cycle on `ds_fill0` (the nearer word) and `ds_fill1`. The return stack works the same way, with one word spilled or refilled. All window, status and flag outputs are registered and change on the clock edge that accepts the opcode. The spill and refill strobes are combinational from the presented opcode.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset the top, next and third elements, the return top and the status are all zero. Every user variable reads zero, and `br_taken`, `illegal` and `brk_hit` are low.
- R2: Opcode 1 pushes `op_lit[7:0]` zero-extended to 16 bits, and opcode 2 pushes `op_lit`, whose bits 7:0 carry the first literal byte. A push moves top to next and next to third, and spills the old third through `ds_push` with `ds_spill`.
- R3: Opcodes 3 (add), 33 (and), 34 (or) and 35 (xor) replace the top with next op top. They drop next (third moves up, `ds_fill0` becomes third, `ds_pop`=1) and set status bit 1 when the result is zero.
- R4: Opcode 4 forms the two's-complement negation of the top and adds it to next, leaving next minus top on top. It pops and sets the zero flag as R3 does.
- R5: Opcode 6 shifts the top left by one and opcode 7 shifts it right by one, both with zero fill. The bit shifted out goes to status bit 0, and status bit 1 shows a zero result.
- R6: Opcode 8 pushes a copy of the top, opcode 9 exchanges top and next, and opcode 10 pops the top.
- R7: Opcode 11 brings the third element to the top, moving top and next down one place. Opcode 12 moves the top to third place, moving next and third up.
- R8: Opcode 13 copies the top to the return top, spills the old return top with `rs_push`, and pops the data stack. Opcode 14 pushes the return top and refills it from `rs_fill` with `rs_pop`. Opcode 15 pushes the return top without changing it.
- R9: The user variable index is the top masked to 5 bits. Opcode 39 replaces the top with the indexed variable. Opcode 40 writes next into the variable and opcode 41 adds next to it, and both pop two words (`ds_pop`=2).
- R10: Opcodes 42 and 43 add one to and subtract one from the indexed variable in place, with the carry or borrow running across all 16 bits and wrapping. Both then pop the index.
- R11: Branch opcodes pulse `br_taken` in the cycle after acceptance and leave all other state unchanged. The conditions are: 23 when the top is zero, 24 when it is nonzero, 25 when carry is clear, 26 when carry is set, 27 when the zero flag is set, 28 when it is clear, and 36 always.
- R12: Opcodes 0 and 5 change nothing, and opcode 44 changes nothing but pulses `brk_hit` for one cycle. Every opcode not named in R2 to R11 or here changes nothing and pulses `illegal` for one cycle.
- R13: While `op_valid` is low no state changes, and all spill and refill strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode presented this cycle |
| op_code | input | 8 | Opcode byte |
| op_lit | input | 16 | Literal bytes, first byte in bits 7:0 |
| ds_fill0 | input | 16 | Nearest word below the window in data storage |
| ds_fill1 | input | 16 | Second word below the window |
| rs_fill | input | 16 | Word below the return top in return storage |
| tos | output | 16 | Top of data stack |
| nos | output | 16 | Second data-stack element |
| thd | output | 16 | Third data-stack element |
| rtop | output | 16 | Return-stack top |
| status | output | 2 | Bit 0 carry, bit 1 zero |
| ds_push | output | 1 | Store `ds_spill` into data storage |
| ds_spill | output | 16 | Word spilled from the window |
| ds_pop | output | 2 | Number of words taken from data storage |
| rs_push | output | 1 | Store `rs_spill` into return storage |
| rs_spill | output | 16 | Old return top being spilled |
| rs_pop | output | 1 | Take one word from return storage |
| br_taken | output | 1 | Branch taken, one-cycle pulse |
| illegal | output | 1 | Undefined opcode seen, one-cycle pulse |
| brk_hit | output | 1 | Break opcode seen, one-cycle pulse |

## Verification
Some opcodes move both stacks in one cycle. Opcode 14 pushes the data stack while it pops the return stack, and opcode 13 pops the data stack while it pushes the return stack. The user-variable stores write the file while they also take two words from data storage. The bench reaches each of these by preloading both stacks through earlier literal and move opcodes, so the old third element and the old return top are live and distinct. While the opcode is still presented, it samples all four strobes. After the edge it compares the window, return top, spilled values and a fetched-back variable against its own stack model.

// File: rtl/stk_exec_pkg.sv
`timescale 1ns/1ps
package stk_exec_pkg;

    localparam logic [7:0] OPC_NOP    = 8'd0;
    localparam logic [7:0] OPC_LIT8   = 8'd1;
    localparam logic [7:0] OPC_LIT16  = 8'd2;
    localparam logic [7:0] OPC_ADD    = 8'd3;
    localparam logic [7:0] OPC_SUB    = 8'd4;
    localparam logic [7:0] OPC_CMP    = 8'd5;
    localparam logic [7:0] OPC_ROL    = 8'd6;
    localparam logic [7:0] OPC_ROR    = 8'd7;
    localparam logic [7:0] OPC_DUP    = 8'd8;
    localparam logic [7:0] OPC_SWAP   = 8'd9;
    localparam logic [7:0] OPC_DROP   = 8'd10;
    localparam logic [7:0] OPC_ROT    = 8'd11;
    localparam logic [7:0] OPC_NROT   = 8'd12;
    localparam logic [7:0] OPC_TO_R   = 8'd13;
    localparam logic [7:0] OPC_R_FROM = 8'd14;
    localparam logic [7:0] OPC_R_COPY = 8'd15;
    localparam logic [7:0] OPC_IF     = 8'd23;
    localparam logic [7:0] OPC_IFN    = 8'd24;
    localparam logic [7:0] OPC_BCC    = 8'd25;
    localparam logic [7:0] OPC_BCS    = 8'd26;
    localparam logic [7:0] OPC_BZ     = 8'd27;
    localparam logic [7:0] OPC_BNZ    = 8'd28;
    localparam logic [7:0] OPC_AND    = 8'd33;
    localparam logic [7:0] OPC_OR     = 8'd34;
    localparam logic [7:0] OPC_XOR    = 8'd35;
    localparam logic [7:0] OPC_BR     = 8'd36;
    localparam logic [7:0] OPC_UGET   = 8'd39;
    localparam logic [7:0] OPC_UPUT   = 8'd40;
    localparam logic [7:0] OPC_UADD   = 8'd41;
    localparam logic [7:0] OPC_UINC   = 8'd42;
    localparam logic [7:0] OPC_UDEC   = 8'd43;
    localparam logic [7:0] OPC_BRK    = 8'd44;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_ROL, ALU_ROR
    } alu_op_e;

    typedef enum logic [2:0] {
        UV_NONE, UV_WRITE, UV_ACCUM, UV_INC, UV_DEC
    } uv_op_e;

    typedef enum logic [2:0] {
        CND_TOS_Z, CND_TOS_NZ, CND_C_CLR, CND_C_SET, CND_Z_SET, CND_Z_CLR, CND_ALWAYS
    } cond_e;

    typedef enum logic [3:0] {
        WIN_HOLD, WIN_PUSH, WIN_POP1, WIN_POP2, WIN_BINARY,
        WIN_UNARY, WIN_UFETCH, WIN_SWAP, WIN_ROT, WIN_NROT
    } win_e;

    typedef enum logic [1:0] {
        PSH_LIT8, PSH_LIT16, PSH_TOS, PSH_RTOP
    } psrc_e;

    typedef struct packed {
        logic       legal;
        logic       brk;
        win_e       win;
        psrc_e      psrc;
        logic       alu_en;
        alu_op_e    alu_op;
        logic       rs_push;
        logic       rs_pop;
        uv_op_e     uv_op;
        logic       branch;
        cond_e      cond;
        logic       push;
        logic [1:0] pop_cnt;
    } dec_t;

endpackage

// File: rtl/stk_exec_decode.sv
`timescale 1ns/1ps
module stk_exec_decode
    import stk_exec_pkg::*;
(
    input  logic [7:0] op_code,
    output dec_t       dec
);

    dec_t d;

    always_comb begin
        d        = '0;
        d.win    = WIN_HOLD;
        d.psrc   = PSH_LIT8;
        d.alu_op = ALU_ADD;
        d.uv_op  = UV_NONE;
        d.cond   = CND_ALWAYS;
        d.legal  = 1'b1;
        case (op_code)
            OPC_NOP, OPC_CMP: ;
            OPC_BRK:    d.brk = 1'b1;
            OPC_LIT8:   begin d.win = WIN_PUSH; d.psrc = PSH_LIT8;  end
            OPC_LIT16:  begin d.win = WIN_PUSH; d.psrc = PSH_LIT16; end
            OPC_ADD:    begin d.win = WIN_BINARY; d.alu_en = 1'b1; d.alu_op = ALU_ADD; end
            OPC_SUB:    begin d.win = WIN_BINARY; d.alu_en = 1'b1; d.alu_op = ALU_SUB; end
            OPC_AND:    begin d.win = WIN_BINARY; d.alu_en = 1'b1; d.alu_op = ALU_AND; end
            OPC_OR:     begin d.win = WIN_BINARY; d.alu_en = 1'b1; d.alu_op = ALU_OR;  end
            OPC_XOR:    begin d.win = WIN_BINARY; d.alu_en = 1'b1; d.alu_op = ALU_XOR; end
            OPC_ROL:    begin d.win = WIN_UNARY;  d.alu_en = 1'b1; d.alu_op = ALU_ROL; end
            OPC_ROR:    begin d.win = WIN_UNARY;  d.alu_en = 1'b1; d.alu_op = ALU_ROR; end
            OPC_DUP:    begin d.win = WIN_PUSH; d.psrc = PSH_TOS; end
            OPC_SWAP:   d.win = WIN_SWAP;
            OPC_DROP:   d.win = WIN_POP1;
            OPC_ROT:    d.win = WIN_ROT;
            OPC_NROT:   d.win = WIN_NROT;
            OPC_TO_R:   begin d.win = WIN_POP1; d.rs_push = 1'b1; end
            OPC_R_FROM: begin d.win = WIN_PUSH; d.psrc = PSH_RTOP; d.rs_pop = 1'b1; end
            OPC_R_COPY: begin d.win = WIN_PUSH; d.psrc = PSH_RTOP; end
            OPC_IF:     begin d.branch = 1'b1; d.cond = CND_TOS_Z;  end
            OPC_IFN:    begin d.branch = 1'b1; d.cond = CND_TOS_NZ; end
            OPC_BCC:    begin d.branch = 1'b1; d.cond = CND_C_CLR;  end
            OPC_BCS:    begin d.branch = 1'b1; d.cond = CND_C_SET;  end
            OPC_BZ:     begin d.branch = 1'b1; d.cond = CND_Z_SET;  end
            OPC_BNZ:    begin d.branch = 1'b1; d.cond = CND_Z_CLR;  end
            OPC_BR:     begin d.branch = 1'b1; d.cond = CND_ALWAYS; end
            OPC_UGET:   d.win = WIN_UFETCH;
            OPC_UPUT:   begin d.win = WIN_POP2; d.uv_op = UV_WRITE; end
            OPC_UADD:   begin d.win = WIN_POP2; d.uv_op = UV_ACCUM; end
            OPC_UINC:   begin d.win = WIN_POP1; d.uv_op = UV_INC;   end
            OPC_UDEC:   begin d.win = WIN_POP1; d.uv_op = UV_DEC;   end
            default:    d.legal = 1'b0;
        endcase
        d.push    = (d.win == WIN_PUSH);
        d.pop_cnt = (d.win == WIN_POP2) ? 2'd2 :
                    ((d.win == WIN_POP1) || (d.win == WIN_BINARY)) ? 2'd1 : 2'd0;
    end

    assign dec = d;

    always_comb begin
        AST_ONE_STACK_DIR: assert (!(dec.push && (dec.pop_cnt != 2'd0))); // R2
    end

endmodule

// File: rtl/stk_exec_alu.sv
`timescale 1ns/1ps
module stk_exec_alu
    import stk_exec_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [DW-1:0]    res,
    output logic             cout
);

    logic [DW-1:0] neg_a;

    assign neg_a = ~a + DW'(1);

    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            ALU_ADD: res = b + a;
            ALU_SUB: res = b + neg_a;
            ALU_AND: res = b & a;
            ALU_OR:  res = b | a;
            ALU_XOR: res = b ^ a;
            ALU_ROL: {cout, res} = {a, 1'b0};
            ALU_ROR: {res, cout} = {1'b0, a};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_exec_cond.sv
`timescale 1ns/1ps
module stk_exec_cond
    import stk_exec_pkg::*;
#(
    parameter int DW = 16
) (
    input  cond_e         cond,
    input  logic [DW-1:0] tos,
    input  logic [1:0]    status,
    output logic          taken
);

    logic tos_zero;

    assign tos_zero = (tos == '0);

    always_comb begin
        case (cond)
            CND_TOS_Z:  taken = tos_zero;
            CND_TOS_NZ: taken = !tos_zero;
            CND_C_CLR:  taken = !status[ST_C];
            CND_C_SET:  taken = status[ST_C];
            CND_Z_SET:  taken = status[ST_Z];
            CND_Z_CLR:  taken = !status[ST_Z];
            CND_ALWAYS: taken = 1'b1;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_exec_uvar.sv
`timescale 1ns/1ps
module stk_exec_uvar
    import stk_exec_pkg::*;
#(
    parameter int DW   = 16,
    parameter int UV_N = 32,
    localparam int AW  = $clog2(UV_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx,
    input  uv_op_e        op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [UV_N-1:0][DW-1:0] file_d, file_q;

    assign rdata = file_q[idx];

    always_comb begin
        file_d = file_q;
        case (op)
            UV_WRITE: file_d[idx] = wdata;
            UV_ACCUM: file_d[idx] = file_q[idx] + wdata;
            UV_INC:   file_d[idx] = file_q[idx] + DW'(1);
            UV_DEC:   file_d[idx] = file_q[idx] - DW'(1);
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) file_q <= '0;
        else        file_q <= file_d;
    end

    AST_UINC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == UV_INC) |=> (file_q[$past(idx)] == DW'($past(file_q[idx]) + DW'(1)))); // R10

    AST_UDEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == UV_DEC) |=> (DW'(file_q[$past(idx)] + DW'(1)) == $past(file_q[idx]))); // R10

endmodule

// File: rtl/stk_exec_unit.sv
`timescale 1ns/1ps
module stk_exec_unit
    import stk_exec_pkg::*;
#(
    parameter int DW   = 16,
    parameter int UV_N = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [7:0]    op_code,
    input  logic [DW-1:0] op_lit,
    input  logic [DW-1:0] ds_fill0,
    input  logic [DW-1:0] ds_fill1,
    input  logic [DW-1:0] rs_fill,
    output logic [DW-1:0] tos,
    output logic [DW-1:0] nos,
    output logic [DW-1:0] thd,
    output logic [DW-1:0] rtop,
    output logic [1:0]    status,
    output logic          ds_push,
    output logic [DW-1:0] ds_spill,
    output logic [1:0]    ds_pop,
    output logic          rs_push,
    output logic [DW-1:0] rs_spill,
    output logic          rs_pop,
    output logic          br_taken,
    output logic          illegal,
    output logic          brk_hit
);

    localparam int UV_AW  = $clog2(UV_N);
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [DW-1:0] tos;
        logic [DW-1:0] nos;
        logic [DW-1:0] thd;
        logic [DW-1:0] rtop;
        logic [1:0]    status;
        logic          br;
        logic          ill;
        logic          brk;
    } st_t;

    st_t           s_d, s_q;
    dec_t          dec;
    logic [DW-1:0] alu_res;
    logic          alu_cout;
    logic          cond_hit;
    logic [DW-1:0] uv_rdata;
    logic [DW-1:0] push_val;
    uv_op_e        uv_op;

    stk_exec_decode u_decode (
        .op_code (op_code),
        .dec     (dec)
    );

    stk_exec_alu #(.DW(DW)) u_alu (
        .op   (dec.alu_op),
        .a    (s_q.tos),
        .b    (s_q.nos),
        .res  (alu_res),
        .cout (alu_cout)
    );

    stk_exec_cond #(.DW(DW)) u_cond (
        .cond   (dec.cond),
        .tos    (s_q.tos),
        .status (s_q.status),
        .taken  (cond_hit)
    );

    assign uv_op = op_valid ? dec.uv_op : UV_NONE;

    stk_exec_uvar #(.DW(DW), .UV_N(UV_N)) u_uvar (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (s_q.tos[UV_AW-1:0]),
        .op    (uv_op),
        .wdata (s_q.nos),
        .rdata (uv_rdata)
    );

    always_comb begin
        case (dec.psrc)
            PSH_LIT8:  push_val = DW'(op_lit[BYTE_W-1:0]);
            PSH_LIT16: push_val = op_lit;
            PSH_TOS:   push_val = s_q.tos;
            default:   push_val = s_q.rtop;
        endcase
    end

    always_comb begin
        s_d     = s_q;
        s_d.br  = 1'b0;
        s_d.ill = 1'b0;
        s_d.brk = 1'b0;
        if (op_valid) begin
            case (dec.win)
                WIN_PUSH: begin
                    s_d.thd = s_q.nos;
                    s_d.nos = s_q.tos;
                    s_d.tos = push_val;
                end
                WIN_POP1: begin
                    s_d.tos = s_q.nos;
                    s_d.nos = s_q.thd;
                    s_d.thd = ds_fill0;
                end
                WIN_POP2: begin
                    s_d.tos = s_q.thd;
                    s_d.nos = ds_fill0;
                    s_d.thd = ds_fill1;
                end
                WIN_BINARY: begin
                    s_d.tos = alu_res;
                    s_d.nos = s_q.thd;
                    s_d.thd = ds_fill0;
                end
                WIN_UNARY:  s_d.tos = alu_res;
                WIN_UFETCH: s_d.tos = uv_rdata;
                WIN_SWAP: begin
                    s_d.tos = s_q.nos;
                    s_d.nos = s_q.tos;
                end
                WIN_ROT: begin
                    s_d.tos = s_q.thd;
                    s_d.nos = s_q.tos;
                    s_d.thd = s_q.nos;
                end
                WIN_NROT: begin
                    s_d.tos = s_q.nos;
                    s_d.nos = s_q.thd;
                    s_d.thd = s_q.tos;
                end
                default: ;
            endcase
            if (dec.alu_en) begin
                s_d.status[ST_Z] = (alu_res == '0);
                if ((dec.alu_op == ALU_ROL) || (dec.alu_op == ALU_ROR))
                    s_d.status[ST_C] = alu_cout;
            end
            if (dec.rs_push) s_d.rtop = s_q.tos;
            if (dec.rs_pop)  s_d.rtop = rs_fill;
            s_d.br  = dec.branch && cond_hit;
            s_d.ill = !dec.legal;
            s_d.brk = dec.brk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tos      = s_q.tos;
    assign nos      = s_q.nos;
    assign thd      = s_q.thd;
    assign rtop     = s_q.rtop;
    assign status   = s_q.status;
    assign br_taken = s_q.br;
    assign illegal  = s_q.ill;
    assign brk_hit  = s_q.brk;
    assign ds_push  = op_valid && dec.push;
    assign ds_spill = s_q.thd;
    assign ds_pop   = op_valid ? dec.pop_cnt : 2'd0;
    assign rs_push  = op_valid && dec.rs_push;
    assign rs_spill = s_q.rtop;
    assign rs_pop   = op_valid && dec.rs_pop;

    AST_ILLEGAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dec.legal) |=> ($stable(tos) && $stable(nos) && $stable(thd)
                                      && $stable(rtop) && $stable(status) && illegal)); // R12

    AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OPC_ROL)) |=>
            ((status[ST_C] == $past(tos[DW-1])) && (tos == DW'($past(tos) << 1)))); // R5

    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OPC_SWAP)) |=>
            ((tos == $past(nos)) && (nos == $past(tos)) && $stable(thd))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(tos) && $stable(nos) && $stable(thd)
                       && $stable(rtop) && $stable(status))); // R13

    AST_BR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> $past(op_valid)); // R11

endmodule

// File: tb/stk_exec_unit_bench.sv
`timescale 1ns/1ps
module stk_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = '0;
    logic [15:0] op_lit = '0;
    logic [15:0] ds_fill0, ds_fill1, rs_fill;
    logic [15:0] tos, nos, thd, rtop, ds_spill, rs_spill;
    logic [1:0]  status, ds_pop;
    logic        ds_push, rs_push, rs_pop, br_taken, illegal, brk_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stk_exec_unit u_stk_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_lit(op_lit),
        .ds_fill0(ds_fill0), .ds_fill1(ds_fill1), .rs_fill(rs_fill),
        .tos(tos), .nos(nos), .thd(thd), .rtop(rtop), .status(status),
        .ds_push(ds_push), .ds_spill(ds_spill), .ds_pop(ds_pop),
        .rs_push(rs_push), .rs_spill(rs_spill), .rs_pop(rs_pop),
        .br_taken(br_taken), .illegal(illegal), .brk_hit(brk_hit)
    );

    // backing storage below the window, acting as the outside stack memory
    logic [15:0] xds [0:31];
    logic [15:0] xrs [0:31];
    int xsp = 0;
    int xrsp = 0;

    assign ds_fill0 = (xsp >= 1) ? xds[(xsp-1) & 31] : 16'h0000;
    assign ds_fill1 = (xsp >= 2) ? xds[(xsp-2) & 31] : 16'h0000;
    assign rs_fill  = (xrsp >= 1) ? xrs[(xrsp-1) & 31] : 16'h0000;

    always @(posedge clk) begin
        if (!rst_n) begin
            xsp  <= 0;
            xrsp <= 0;
        end else begin
            if (ds_push) begin
                xds[xsp & 31] <= ds_spill;
                xsp <= xsp + 1;
            end else if (ds_pop != 2'd0) begin
                xsp <= (xsp >= int'(ds_pop)) ? xsp - int'(ds_pop) : 0;
            end
            if (rs_push) begin
                xrs[xrsp & 31] <= rs_spill;
                xrsp <= xrsp + 1;
            end else if (rs_pop) begin
                xrsp <= (xrsp >= 1) ? xrsp - 1 : 0;
            end
        end
    end

    // reference model
    logic [15:0] ms [0:15];
    logic [15:0] mr [0:15];
    logic [15:0] muv [0:31];
    logic [1:0]  mst;
    logic        eb, ei, ek, e_push, e_rpush, e_rpop;
    logic [1:0]  e_pop;
    logic [31:0] seed = 32'h1234_5678;

    task automatic rnd16(output logic [15:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed[23:8];
    endtask

    task automatic m_push(input logic [15:0] v);
        for (int i = 15; i > 0; i--) ms[i] = ms[i-1];
        ms[0] = v;
    endtask

    task automatic m_pop();
        for (int i = 0; i < 15; i++) ms[i] = ms[i+1];
        ms[15] = 16'h0000;
    endtask

    task automatic m_rpush(input logic [15:0] v);
        for (int i = 15; i > 0; i--) mr[i] = mr[i-1];
        mr[0] = v;
    endtask

    task automatic m_rpop();
        for (int i = 0; i < 15; i++) mr[i] = mr[i+1];
        mr[15] = 16'h0000;
    endtask

    task automatic m_clear();
        for (int i = 0; i < 16; i++) begin ms[i] = 16'h0; mr[i] = 16'h0; end
        for (int i = 0; i < 32; i++) muv[i] = 16'h0;
        mst = 2'b00;
        eb = 0; ei = 0; ek = 0;
    endtask

    task automatic m_step(input logic [7:0] op, input logic [15:0] lit, input bit v);
        logic [15:0] r, a, b, t;
        int ix;
        eb = 0; ei = 0; ek = 0; e_push = 0; e_pop = 2'd0; e_rpush = 0; e_rpop = 0;
        if (v) begin
            a = ms[0]; b = ms[1]; ix = int'(ms[0][4:0]);
            case (op)
                8'd0, 8'd5: ;
                8'd44: ek = 1;
                8'd1: begin m_push({8'h00, lit[7:0]}); e_push = 1; end
                8'd2: begin m_push(lit); e_push = 1; end
                8'd3, 8'd4, 8'd33, 8'd34, 8'd35: begin
                    case (op)
                        8'd3:    r = b + a;
                        8'd4:    r = b - a;
                        8'd33:   r = b & a;
                        8'd34:   r = b | a;
                        default: r = b ^ a;
                    endcase
                    m_pop(); ms[0] = r; mst[1] = (r == 16'h0); e_pop = 2'd1;
                end
                8'd6: begin mst[0] = a[15]; r = {a[14:0], 1'b0}; ms[0] = r; mst[1] = (r == 16'h0); end
                8'd7: begin mst[0] = a[0];  r = {1'b0, a[15:1]}; ms[0] = r; mst[1] = (r == 16'h0); end
                8'd8:  begin m_push(a); e_push = 1; end
                8'd9:  begin ms[0] = b; ms[1] = a; end
                8'd10: begin m_pop(); e_pop = 2'd1; end
                8'd11: begin t = ms[2]; ms[2] = b; ms[1] = a; ms[0] = t; end
                8'd12: begin ms[0] = b; ms[1] = ms[2]; ms[2] = a; end
                8'd13: begin m_rpush(a); m_pop(); e_pop = 2'd1; e_rpush = 1; end
                8'd14: begin t = mr[0]; m_rpop(); m_push(t); e_push = 1; e_rpop = 1; end
                8'd15: begin m_push(mr[0]); e_push = 1; end
                8'd23: eb = (a == 16'h0);
                8'd24: eb = (a != 16'h0);
                8'd25: eb = !mst[0];
                8'd26: eb = mst[0];
                8'd27: eb = mst[1];
                8'd28: eb = !mst[1];
                8'd36: eb = 1;
                8'd39: ms[0] = muv[ix];
                8'd40: begin muv[ix] = b; m_pop(); m_pop(); e_pop = 2'd2; end
                8'd41: begin muv[ix] = muv[ix] + b; m_pop(); m_pop(); e_pop = 2'd2; end
                8'd42: begin muv[ix] = muv[ix] + 16'd1; m_pop(); e_pop = 2'd1; end
                8'd43: begin muv[ix] = muv[ix] - 16'd1; m_pop(); e_pop = 2'd1; end
                default: ei = 1;
            endcase
        end
    endtask

    function automatic string req_of(input logic [7:0] op, input bit v);
        if (!v) return "R13";
        case (op)
            8'd1, 8'd2: return "R2";
            8'd3, 8'd33, 8'd34, 8'd35: return "R3";
            8'd4: return "R4";
            8'd6, 8'd7: return "R5";
            8'd8, 8'd9, 8'd10: return "R6";
            8'd11, 8'd12: return "R7";
            8'd13, 8'd14, 8'd15: return "R8";
            8'd39, 8'd40, 8'd41: return "R9";
            8'd42, 8'd43: return "R10";
            8'd23, 8'd24, 8'd25, 8'd26, 8'd27, 8'd28, 8'd36: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic compare_state(input string tag, input logic [7:0] op);
        checks++;
        if ({tos, nos, thd, rtop, status, br_taken, illegal, brk_hit} !==
            {ms[0], ms[1], ms[2], mr[0], mst, eb, ei, ek}) begin
            errors++;
            $display("FAIL %s op=%0d tos=%h/%h nos=%h/%h thd=%h/%h rtop=%h/%h st=%b/%b br=%b/%b ill=%b/%b brk=%b/%b (actual/expected)",
                     tag, op, tos, ms[0], nos, ms[1], thd, ms[2], rtop, mr[0], status, mst,
                     br_taken, eb, illegal, ei, brk_hit, ek);
        end
    endtask

    task automatic do_op(input logic [7:0] op, input logic [15:0] lit, input bit v);
        logic g_push, g_rpush, g_rpop;
        logic [1:0] g_pop;
        @(negedge clk);
        op_valid = v; op_code = op; op_lit = lit;
        #1;
        g_push = ds_push; g_pop = ds_pop; g_rpush = rs_push; g_rpop = rs_pop;
        @(negedge clk);
        op_valid = 1'b0;
        m_step(op, lit, v);
        checks++;
        if ({g_push, g_pop, g_rpush, g_rpop} !== {e_push, e_pop, e_rpush, e_rpop}) begin
            errors++;
            $display("FAIL %s op=%0d strobes push/pop/rpush/rpop=%b/%0d/%b/%b expected %b/%0d/%b/%b",
                     req_of(op, v), op, g_push, g_pop, g_rpush, g_rpop, e_push, e_pop, e_rpush, e_rpop);
        end
        compare_state(req_of(op, v), op);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
        compare_state("R1", 8'd0);
    endtask

    initial begin
        logic [15:0] r, s, u, a, b, c, t, q;
        logic [4:0]  ui;
        m_clear();
        do_reset();
        // R1: every user variable reads zero after reset
        for (int i = 0; i < 32; i++) begin
            do_op(8'd2, 16'(i), 1'b1);
            do_op(8'd39, 16'h0, 1'b1);
            checks++;
            if (tos !== 16'h0000) begin
                errors++;
                $display("FAIL R1 uvar %0d after reset got %h expected 0000", i, tos);
            end
        end
        // sweep every opcode under preloaded stacks
        for (int pass = 0; pass < 2; pass++) begin
            for (int op = 0; op < 256; op++) begin
                do_reset();
                rnd16(r); rnd16(s); rnd16(u); rnd16(a); rnd16(b); rnd16(c); rnd16(t); rnd16(q);
                ui = t[4:0];
                if (op[0]) s = 16'h8000;
                if (pass == 1 && op[1]) t = 16'h0000;
                else if (pass == 0) t = {t[15:5], ui};
                do_op(8'd2, r, 1'b1);
                do_op(8'd13, 16'h0, 1'b1);
                do_op(8'd2, s, 1'b1);
                do_op(8'd6, 16'h0, 1'b1);
                do_op(8'd10, 16'h0, 1'b1);
                do_op(8'd2, u, 1'b1);
                do_op(8'd2, {11'h0, t[4:0]}, 1'b1);
                do_op(8'd40, 16'h0, 1'b1);
                do_op(8'd2, a, 1'b1);
                do_op(8'd2, b, 1'b1);
                do_op(8'd2, c, 1'b1);
                do_op(8'd2, t, 1'b1);
                do_op(q[7:0], q, 1'b0);
                do_op(8'(op), q, 1'b1);
                do_op(8'd2, t, 1'b1);
                do_op(8'd39, 16'h0, 1'b1);
            end
        end
        // R10: wrap across the byte boundary and the word boundary
        do_reset();
        do_op(8'd2, 16'hFFFF, 1'b1); do_op(8'd1, 16'h0009, 1'b1); do_op(8'd40, 16'h0, 1'b1);
        do_op(8'd1, 16'h0009, 1'b1); do_op(8'd42, 16'h0, 1'b1);
        do_op(8'd1, 16'h0009, 1'b1); do_op(8'd39, 16'h0, 1'b1);
        checks++;
        if (tos !== 16'h0000) begin errors++; $display("FAIL R10 inc wrap got %h expected 0000", tos); end
        do_op(8'd1, 16'h0009, 1'b1); do_op(8'd43, 16'h0, 1'b1);
        do_op(8'd1, 16'h0009, 1'b1); do_op(8'd39, 16'h0, 1'b1);
        checks++;
        if (tos !== 16'hFFFF) begin errors++; $display("FAIL R10 dec wrap got %h expected ffff", tos); end
        do_op(8'd2, 16'h00FF, 1'b1); do_op(8'd1, 16'h0003, 1'b1); do_op(8'd40, 16'h0, 1'b1);
        do_op(8'd1, 16'h0003, 1'b1); do_op(8'd42, 16'h0, 1'b1);
        do_op(8'd1, 16'h0003, 1'b1); do_op(8'd39, 16'h0, 1'b1);
        checks++;
        if (tos !== 16'h0100) begin errors++; $display("FAIL R10 byte carry got %h expected 0100", tos); end
        // R9: index masked to five bits
        do_op(8'd2, 16'h1234, 1'b1); do_op(8'd2, 16'hFFE3, 1'b1); do_op(8'd40, 16'h0, 1'b1);
        do_op(8'd1, 16'h0003, 1'b1); do_op(8'd39, 16'h0, 1'b1);
        checks++;
        if (tos !== 16'h1234) begin errors++; $display("FAIL R9 masked index got %h expected 1234", tos); end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog expired got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule